// File: doc/BRIEF.md
# Strobed Three-Wire Serial Command Port

This block is the host-facing port of a display controller. A host frames each transfer by pulling a strobe low, then clocks bytes in on a data line, least significant bit first, sampled on the rising edge of its serial clock. The first complete byte of a frame is a command. Bytes that follow in the same frame are data, and the command decides what happens to them. They can be display memory writes with an address that advances or stays put, a write to the LED port, or ignored bytes while the block returns key-matrix or switch data on an open-drain output line.

All three serial inputs are brought into the system clock domain through two-flop synchronisers, and their edges are detected there. Every downstream effect appears as a one-cycle strobe with its payload. Any strobe edge returns the port to waiting for a command, and a byte cut short by the strobe is thrown away.

Top module: `strobed_serial_if`

## Requirements
- R1: Serial data is taken on each rising edge of the serial clock while the strobe is low, least significant bit first, and a byte is complete after eight such edges.
- R2: The first complete byte after the strobe falls is a command, classed by bits 7:6. Class 00 pulses `mode_we_o` with bits 5:0 on `mode_code_o`. Class 10 pulses `ctrl_we_o` with bits 5:0 on `ctrl_code_o`. Every further byte in the frame is data, even if its pattern looks like a command. After reset all strobes and `ser_dout_low_o` are 0.
- R3: Class 01 is a data command and issues no strobe of its own. Bits 1:0 pick the target: 00 display, 01 LED port, 10 key read, 11 switch read. Bit 2 set means a fixed address and clear means the address advances. The address mode persists across frames.
- R4: Class 11 loads the display address from bits 4:0, where values above 21 wrap to the value minus 22. Data bytes later in that frame are display writes.
- R5: Each complete display data byte gives a one-cycle `disp_we_o` with the current address and the byte. The address then advances by one, from 21 back to 0, unless the fixed mode is set.
- R6: Each complete LED data byte gives a one-cycle `led_we_o` with the byte's bits 3:0. Bits 7:4 are ignored.
- R7: In a read frame, the output changes only after a falling serial clock edge. The k-th falling edge after the command presents stream bit k. The key stream is `key_bits_i` bits 0 to 23. The switch stream is one byte, switches in bits 3:0 and zero in bits 7:4. Past the end of the stream the line reads 1.
- R8: The output is open-drain: `ser_dout_low_o` is 1 only to drive a 0. It is 0 outside read frames, while the strobe is high, and in a read frame until the first falling edge.
- R9: Either strobe edge resets the bit count and the frame. A byte left incomplete when the strobe rises, whether command or data, produces no strobe.
- R10: Serial clock edges while the strobe is high change nothing: no bits are counted and no byte is formed.
- R11: Data bytes in a read frame, or after a mode or control command, produce no strobe.
- R12: Key or switch data is captured when the read command completes. Later input changes do not alter that frame's stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_stb_i | input | 1 | Frame strobe, active low, asynchronous |
| ser_din_i | input | 1 | Serial data in, asynchronous |
| key_bits_i | input | 24 | Key matrix state, bit 0 first in the read stream |
| sw_bits_i | input | 4 | Switch inputs |
| ser_dout_low_o | output | 1 | Open-drain pull-down for the data-out line (1 drives 0) |
| disp_we_o | output | 1 | Display memory write strobe |
| disp_addr_o | output | 5 | Display memory address |
| disp_data_o | output | 8 | Display memory write byte |
| led_we_o | output | 1 | LED port write strobe |
| led_data_o | output | 4 | LED port value |
| mode_we_o | output | 1 | Mode setting strobe |
| mode_code_o | output | 6 | Mode setting code |
| ctrl_we_o | output | 1 | Display control strobe |
| ctrl_code_o | output | 6 | Display control code |

## Verification
The port is driven with complete frames of every command class, with display address loads that start near the top of the range, and with address values beyond it. The auto-advance and fixed modes are then told apart by the addresses that come back. Aborted frames, cut off inside a command or a data byte, are followed by clean frames, so that any leftover bit count would show up as a wrong byte. Clock pulses sent while the strobe is high are checked the same way. Read frames sample the line the way a host would, on the rising edge. They change the key inputs after the command to show the capture, and they read past the stream end and send data bytes to show that nothing is written.

// File: rtl/sis_pkg.sv
package sis_pkg;

    localparam int BYTE_W       = 8;
    localparam int ADDR_FIELD_W = 5;

    typedef enum logic [1:0] {
        CL_MODE = 2'b00,
        CL_DATA = 2'b01,
        CL_CTRL = 2'b10,
        CL_ADDR = 2'b11
    } cmd_class_t;

    typedef enum logic [1:0] {
        TG_DISP = 2'b00,
        TG_LED  = 2'b01,
        TG_KEYS = 2'b10,
        TG_SW   = 2'b11
    } target_t;

    typedef enum logic [2:0] {
        FR_CMD,
        FR_DISP,
        FR_LED,
        FR_READ,
        FR_SKIP
    } frame_t;

    typedef struct packed {
        cmd_class_t  cls;
        logic [5:0]  arg;
    } cmd_t;

    function automatic int fold_addr(int v, int last);
        return (v > last) ? v - (last + 1) : v;
    endfunction

    function automatic int next_addr(int v, int last);
        return (v >= last) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/sis_sync.sv
module sis_sync #(
    parameter int               WIDTH  = 3,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE   = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= {STAGES{IDLE[b]}};
            else     chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end
        assign level_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/sis_byte_rx.sv
module sis_byte_rx
    import sis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_rise,
    input  logic              stb_level,
    input  logic              stb_edge,
    input  logic              din_level,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int CW = $clog2(BYTE_W);

    logic [CW-1:0]     cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] next_sh;

    assign next_sh = {din_level, sh_q[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q        <= '0;
            sh_q         <= '0;
            byte_valid_o <= 1'b0;
            byte_o       <= '0;
        end else begin
            byte_valid_o <= 1'b0;
            if (stb_edge) begin
                cnt_q <= '0;
            end else if (sclk_rise && !stb_level) begin
                sh_q <= next_sh;
                if (cnt_q == CW'(BYTE_W - 1)) begin
                    byte_valid_o <= 1'b1;
                    byte_o       <= next_sh;
                    cnt_q        <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_HIGH_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (stb_level && !stb_edge) |=> ($stable(cnt_q) && !byte_valid_o)); // R10
    AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stb_edge |=> (cnt_q == '0 && !byte_valid_o)); // R9
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |=> !byte_valid_o); // R1
endmodule

// File: rtl/sis_cmd_ctrl.sv
module sis_cmd_ctrl
    import sis_pkg::*;
#(
    parameter int ADDR_LAST = 21,
    parameter int AW        = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_edge,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              disp_we_o,
    output logic [AW-1:0]     disp_addr_o,
    output logic [7:0]        disp_data_o,
    output logic              led_we_o,
    output logic [3:0]        led_data_o,
    output logic              mode_we_o,
    output logic [5:0]        mode_code_o,
    output logic              ctrl_we_o,
    output logic [5:0]        ctrl_code_o,
    output logic              rd_start_o,
    output logic              rd_sel_sw_o
);
    frame_t        frame_q;
    logic [AW-1:0] addr_q;
    logic          fixed_q;
    cmd_t          cmd;
    target_t       tgt;

    assign cmd = cmd_t'(byte_i);
    assign tgt = target_t'(cmd.arg[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q     <= FR_CMD;
            addr_q      <= '0;
            fixed_q     <= 1'b0;
            disp_we_o   <= 1'b0;
            disp_addr_o <= '0;
            disp_data_o <= '0;
            led_we_o    <= 1'b0;
            led_data_o  <= '0;
            mode_we_o   <= 1'b0;
            mode_code_o <= '0;
            ctrl_we_o   <= 1'b0;
            ctrl_code_o <= '0;
            rd_start_o  <= 1'b0;
            rd_sel_sw_o <= 1'b0;
        end else begin
            disp_we_o  <= 1'b0;
            led_we_o   <= 1'b0;
            mode_we_o  <= 1'b0;
            ctrl_we_o  <= 1'b0;
            rd_start_o <= 1'b0;
            if (stb_edge) begin
                frame_q <= FR_CMD;
            end else if (byte_valid) begin
                unique case (frame_q)
                    FR_CMD: begin
                        unique case (cmd.cls)
                            CL_MODE: begin
                                mode_we_o   <= 1'b1;
                                mode_code_o <= cmd.arg;
                                frame_q     <= FR_SKIP;
                            end
                            CL_CTRL: begin
                                ctrl_we_o   <= 1'b1;
                                ctrl_code_o <= cmd.arg;
                                frame_q     <= FR_SKIP;
                            end
                            CL_ADDR: begin
                                addr_q  <= AW'(fold_addr(32'(cmd.arg[ADDR_FIELD_W-1:0]), ADDR_LAST));
                                frame_q <= FR_DISP;
                            end
                            CL_DATA: begin
                                fixed_q <= cmd.arg[2];
                                unique case (tgt)
                                    TG_DISP: frame_q <= FR_DISP;
                                    TG_LED:  frame_q <= FR_LED;
                                    TG_KEYS, TG_SW: begin
                                        rd_start_o  <= 1'b1;
                                        rd_sel_sw_o <= (tgt == TG_SW);
                                        frame_q     <= FR_READ;
                                    end
                                endcase
                            end
                        endcase
                    end
                    FR_DISP: begin
                        disp_we_o   <= 1'b1;
                        disp_addr_o <= addr_q;
                        disp_data_o <= byte_i;
                        if (!fixed_q) addr_q <= AW'(next_addr(32'(addr_q), ADDR_LAST));
                    end
                    FR_LED: begin
                        led_we_o   <= 1'b1;
                        led_data_o <= byte_i[3:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({disp_we_o, led_we_o, mode_we_o, ctrl_we_o, rd_start_o})); // R2
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        disp_we_o |-> (disp_addr_o <= AW'(ADDR_LAST))); // R4
    AST_WE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        (disp_we_o || led_we_o || mode_we_o || ctrl_we_o) |-> $past(byte_valid)); // R5
    AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (disp_we_o && fixed_q) |-> (addr_q == disp_addr_o)); // R5
    AST_AUTO_STEP: assert property (@(posedge clk) disable iff (rst)
        (disp_we_o && !fixed_q) |->
            (addr_q == ((disp_addr_o == AW'(ADDR_LAST)) ? '0 : disp_addr_o + 1'b1))); // R5
endmodule

// File: rtl/sis_rd_shift.sv
module sis_rd_shift
    import sis_pkg::*;
#(
    parameter int KEY_BITS = 24,
    parameter int SW_BITS  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_start,
    input  logic                rd_sel_sw,
    input  logic [KEY_BITS-1:0] key_bits,
    input  logic [SW_BITS-1:0]  sw_bits,
    input  logic                sclk_fall,
    input  logic                stb_level,
    input  logic                stb_edge,
    output logic                pull_low_o
);
    localparam int STREAM = (KEY_BITS > BYTE_W) ? KEY_BITS : BYTE_W;
    localparam int IW     = $clog2(STREAM + 1);

    logic [STREAM-1:0] snap_q;
    logic [IW-1:0]     len_q;
    logic [IW-1:0]     idx_q;
    logic              active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q     <= '0;
            len_q      <= '0;
            idx_q      <= '0;
            active_q   <= 1'b0;
            pull_low_o <= 1'b0;
        end else if (stb_edge) begin
            active_q   <= 1'b0;
            idx_q      <= '0;
            pull_low_o <= 1'b0;
        end else if (rd_start) begin
            active_q   <= 1'b1;
            idx_q      <= '0;
            pull_low_o <= 1'b0;
            snap_q     <= rd_sel_sw ? STREAM'(sw_bits) : STREAM'(key_bits);
            len_q      <= rd_sel_sw ? IW'(BYTE_W) : IW'(KEY_BITS);
        end else if (sclk_fall && active_q && !stb_level) begin
            if (idx_q < len_q) begin
                pull_low_o <= ~snap_q[idx_q];
                idx_q      <= idx_q + 1'b1;
            end else begin
                pull_low_o <= 1'b0;
            end
        end
    end

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> !pull_low_o); // R8
    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pull_low_o) && pull_low_o) |-> $past(sclk_fall)); // R7
    AST_STB_RELEASE: assert property (@(posedge clk) disable iff (rst)
        stb_edge |=> !pull_low_o); // R9
endmodule

// File: rtl/strobed_serial_if.sv
module strobed_serial_if
    import sis_pkg::*;
#(
    parameter int ADDR_LAST   = 21,
    parameter int KEY_BITS    = 24,
    parameter int SW_BITS     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(ADDR_LAST + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_clk_i,
    input  logic                ser_stb_i,
    input  logic                ser_din_i,
    input  logic [KEY_BITS-1:0] key_bits_i,
    input  logic [SW_BITS-1:0]  sw_bits_i,
    output logic                ser_dout_low_o,
    output logic                disp_we_o,
    output logic [AW-1:0]       disp_addr_o,
    output logic [7:0]          disp_data_o,
    output logic                led_we_o,
    output logic [3:0]          led_data_o,
    output logic                mode_we_o,
    output logic [5:0]          mode_code_o,
    output logic                ctrl_we_o,
    output logic [5:0]          ctrl_code_o
);
    logic [2:0]        lvl;
    logic              sclk_prev_q, stb_prev_q;
    logic              sclk_rise, sclk_fall, stb_edge;
    logic              byte_valid;
    logic [BYTE_W-1:0] rx_byte;
    logic              rd_start, rd_sel_sw;

    sis_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .IDLE(3'b011)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_din_i, ser_stb_i, ser_clk_i}),
        .level_o (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= 1'b1;
            stb_prev_q  <= 1'b1;
        end else begin
            sclk_prev_q <= lvl[0];
            stb_prev_q  <= lvl[1];
        end
    end

    assign sclk_rise = lvl[0] & ~sclk_prev_q;
    assign sclk_fall = ~lvl[0] & sclk_prev_q;
    assign stb_edge  = lvl[1] ^ stb_prev_q;

    sis_byte_rx u_rx (
        .clk          (clk),
        .rst          (rst),
        .sclk_rise    (sclk_rise),
        .stb_level    (lvl[1]),
        .stb_edge     (stb_edge),
        .din_level    (lvl[2]),
        .byte_valid_o (byte_valid),
        .byte_o       (rx_byte)
    );

    sis_cmd_ctrl #(.ADDR_LAST(ADDR_LAST), .AW(AW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .stb_edge    (stb_edge),
        .byte_valid  (byte_valid),
        .byte_i      (rx_byte),
        .disp_we_o   (disp_we_o),
        .disp_addr_o (disp_addr_o),
        .disp_data_o (disp_data_o),
        .led_we_o    (led_we_o),
        .led_data_o  (led_data_o),
        .mode_we_o   (mode_we_o),
        .mode_code_o (mode_code_o),
        .ctrl_we_o   (ctrl_we_o),
        .ctrl_code_o (ctrl_code_o),
        .rd_start_o  (rd_start),
        .rd_sel_sw_o (rd_sel_sw)
    );

    sis_rd_shift #(.KEY_BITS(KEY_BITS), .SW_BITS(SW_BITS)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_start   (rd_start),
        .rd_sel_sw  (rd_sel_sw),
        .key_bits   (key_bits_i),
        .sw_bits    (sw_bits_i),
        .sclk_fall  (sclk_fall),
        .stb_level  (lvl[1]),
        .stb_edge   (stb_edge),
        .pull_low_o (ser_dout_low_o)
    );

    AST_NO_DRIVE_STB_HIGH: assert property (@(posedge clk) disable iff (rst)
        (lvl[1] && stb_prev_q) |-> !ser_dout_low_o); // R8
endmodule

// File: tb/strobed_serial_if_bench.sv
module strobed_serial_if_bench;
    localparam int H = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        sclk = 1'b1, stb = 1'b1, din = 1'b0;
    logic [23:0] keys = '0;
    logic [3:0]  sw = '0;
    logic        dout_low, disp_we, led_we, mode_we, ctrl_we;
    logic [4:0]  disp_addr;
    logic [7:0]  disp_data;
    logic [3:0]  led_data;
    logic [5:0]  mode_code, ctrl_code;

    strobed_serial_if u_strobed_serial_if (
        .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_stb_i(stb), .ser_din_i(din),
        .key_bits_i(keys), .sw_bits_i(sw), .ser_dout_low_o(dout_low),
        .disp_we_o(disp_we), .disp_addr_o(disp_addr), .disp_data_o(disp_data),
        .led_we_o(led_we), .led_data_o(led_data), .mode_we_o(mode_we),
        .mode_code_o(mode_code), .ctrl_we_o(ctrl_we), .ctrl_code_o(ctrl_code)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [14:0] exp_q[$];
    string       tag_q[$];
    logic [14:0] got, expd;
    string       tg;
    logic [7:0]  rv;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // kind: 0 display, 1 LED, 2 mode, 3 control
    task automatic expect_item(int kind, int addr, int data, string req);
        exp_q.push_back({2'(kind), 5'(addr), 8'(data)});
        tag_q.push_back(req);
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_start();
        stb = 1'b0; wait_clk(H);
    endtask

    task automatic frame_end();
        stb = 1'b1; wait_clk(H);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0; din = b[i]; wait_clk(H);
            sclk = 1'b1; wait_clk(H);
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b0; wait_clk(H);
            v[i] = ~dout_low;
            sclk = 1'b1; wait_clk(H);
        end
    endtask

    task automatic drain(string req);
        wait_clk(20);
        chk(exp_q.size() == 0, req, "pending expected items", exp_q.size(), 0);
        exp_q.delete(); tag_q.delete();
    endtask

    // Monitor: compares every strobe the design issues against the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (disp_we || led_we || mode_we || ctrl_we)) begin
                got = disp_we ? {2'd0, disp_addr, disp_data} :
                      led_we  ? {2'd1, 5'd0, 4'd0, led_data} :
                      mode_we ? {2'd2, 5'd0, 2'd0, mode_code} :
                                {2'd3, 5'd0, 2'd0, ctrl_code};
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11", "unexpected strobe", int'(got), 0);
                end else begin
                    expd = exp_q.pop_front();
                    tg   = tag_q.pop_front();
                    chk(got == expd, tg, "strobe item", int'(got), int'(expd));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(10);
        // Reset state
        chk(!dout_low, "R8", "reset dout", dout_low, 0);
        chk(!(disp_we || led_we || mode_we || ctrl_we), "R2", "reset strobes",
            {disp_we, led_we, mode_we, ctrl_we}, 0);

        // R2: mode and control commands
        expect_item(2, 0, 8'h05, "R2");
        frame_start(); send_byte(8'h05); frame_end();
        expect_item(3, 0, 8'h2A, "R2");
        frame_start(); send_byte(8'hAA); frame_end();
        drain("R2");

        // R4/R5: address load near top, auto-advance wraps 21 -> 0
        frame_start(); send_byte(8'h40); frame_end();
        expect_item(0, 20, 8'hA1, "R4");
        expect_item(0, 21, 8'hB2, "R5");
        expect_item(0, 0,  8'hC3, "R5");
        frame_start(); send_byte(8'hD4); send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3); frame_end();
        drain("R5");

        // R3/R4: fixed address mode; out-of-range address 24 folds to 2
        frame_start(); send_byte(8'h44); frame_end();
        expect_item(0, 2, 8'h11, "R3");
        expect_item(0, 2, 8'h22, "R4");
        frame_start(); send_byte(8'hD8); send_byte(8'h11); send_byte(8'h22); frame_end();
        drain("R3");

        // R6: LED write uses only the low nibble; command also selects advancing mode
        expect_item(1, 0, 8'h06, "R6");
        frame_start(); send_byte(8'h41); send_byte(8'hF6); frame_end();
        drain("R6");

        // R9: aborted command and aborted data byte produce nothing
        frame_start(); send_bits(8'h05, 4); frame_end();
        frame_start(); send_byte(8'h40); send_bits(8'hFF, 5); frame_end();
        drain("R9");
        // address still 2, advancing
        expect_item(0, 2, 8'h5A, "R9");
        frame_start(); send_byte(8'h40); send_byte(8'h5A); frame_end();
        drain("R9");

        // R10: clock pulses while strobe high are ignored
        send_bits(8'h02, 8);
        send_bits(8'h01, 3);
        drain("R10");
        expect_item(2, 0, 8'h07, "R10");
        frame_start(); send_byte(8'h07); frame_end();
        drain("R10");

        // R2: a command-looking byte inside a frame is data
        expect_item(0, 3, 8'hC3, "R2");
        frame_start(); send_byte(8'h40); send_byte(8'hC3); frame_end();
        drain("R2");

        // R7/R8/R12: key read, inputs change after the command
        keys = 24'h3C5A81;
        frame_start(); send_byte(8'h42);
        keys = 24'h000000;
        wait_clk(H);
        chk(!dout_low, "R8", "released before first fall", dout_low, 0);
        read_byte(rv); chk(rv == 8'h81, "R7", "key byte 0", rv, 8'h81);
        read_byte(rv); chk(rv == 8'h5A, "R12", "key byte 1", rv, 8'h5A);
        read_byte(rv); chk(rv == 8'h3C, "R7", "key byte 2", rv, 8'h3C);
        read_byte(rv); chk(rv == 8'hFF, "R7", "past stream end", rv, 8'hFF);
        frame_end();
        chk(!dout_low, "R8", "released after frame", dout_low, 0);

        // R7: switch read
        sw = 4'hA;
        frame_start(); send_byte(8'h43);
        read_byte(rv); chk(rv == 8'h0A, "R7", "switch byte", rv, 8'h0A);
        read_byte(rv); chk(rv == 8'hFF, "R7", "switch past end", rv, 8'hFF);
        frame_end();

        // R11: data bytes in a read frame and after a mode command
        frame_start(); send_byte(8'h42); send_byte(8'h99); frame_end();
        expect_item(2, 0, 8'h01, "R11");
        frame_start(); send_byte(8'h01); send_byte(8'h55); frame_end();
        drain("R11");

        // R1: an all-ones command class byte followed by data at advancing address
        expect_item(0, 9, 8'h3E, "R1");
        frame_start(); send_byte(8'hDF); send_byte(8'h3E); frame_end();
        drain("R1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule